// File: doc/BRIEF.md
# Prescaled Inter-Block Interval Timer

This block sets the pace of one DMA channel. When the channel finishes a block, the block holds back permission for the next one. The wait is a programmed interval, counted in ticks of a prescaled clock. The interval is a 16-bit count. A 2-bit selector picks the tick rate: every clock, one in four, one in sixteen, or one in sixty-four. Each block completion restarts the wait from the beginning, and the wait always runs its full length.

The channel controller drives three things into the block: a level that is high while the transfer is in progress, a one-cycle pulse at the end of each block, and the interval and rate fields. The controller starts a block only while `startOk` is high. The first block after the channel becomes active is allowed at once. When the channel goes inactive, the timer clears, so the next activation is again allowed at once.

Top module: `gap_timer`

## Requirements
- R1: Out of reset, `startOk` is low while `chanActive` is low.
- R2: While the timer is idle and `chanActive` is high, `startOk` is high in the same cycle, so the first block after activation waits for nothing.
- R3: A `blockDone` pulse with a nonzero `gapValue`, sampled at a rising edge while the channel is active, makes `startOk` low from the cycle after that edge.
- R4: After such a pulse, `startOk` stays low for exactly `gapValue × D` clock cycles and then rises. D is the divide ratio.
- R5: `tickSel` sets D. The codes are 0 for D = 1, 1 for D = 4, 2 for D = 16 and 3 for D = 64.
- R6: A `blockDone` pulse with `gapValue` equal to 0 leaves `startOk` high in the next cycle, so blocks can run back to back.
- R7: A `blockDone` pulse during a wait restarts the full interval from that edge. The tick prescaler restarts at the same time.
- R8: When `chanActive` goes low, `startOk` is low in the same cycle. Any wait in progress is discarded, so a later activation is allowed at once.
- R9: A `blockDone` pulse while `chanActive` is low is ignored. The next activation still gives `startOk` high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanActive | input | 1 | High while the channel's transfer is in progress |
| blockDone | input | 1 | One-cycle pulse at the end of each block |
| gapValue | input | 16 | Interval between blocks, in prescaled ticks |
| tickSel | input | 2 | Tick-rate code (0: 1, 1: 1/4, 2: 1/16, 3: 1/64) |
| startOk | output | 1 | Permission to start the next block |

## Verification
The bench builds the block with its default parameters: a 16-bit interval field and a 2-bit rate selector. With these widths every step of the divide ladder can be tested, and so can the largest interval of 65535 ticks at the full clock rate, which lands on the upper boundary of the wait counter. Waits as long as 20 ticks at the 1/64 rate are also within reach. This shows that the prescaler reaches its terminal value without dropping a count or adding one.

// File: rtl/gap_timer_pkg.sv
package gap_timer_pkg;
  // strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic clearAll;  // drop both counters
    logic loadGap;   // load interval, restart prescaler
    logic countEn;   // advance prescaler/interval counters
  } gapStrobe_t;
endpackage

// File: rtl/gap_timer_dp.sv
module gap_timer_dp
  import gap_timer_pkg::*;
#(
  parameter int GAP_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gapStrobe_t       stb,
  input  logic [GAP_W-1:0] gapValue,
  input  logic [SEL_W-1:0] tickSel,
  output logic             gapZero,
  output logic             tickLast
);
  localparam int LEVELS = 1 << SEL_W;
  localparam int PRE_W  = (2 * (LEVELS - 1) > 0) ? 2 * (LEVELS - 1) : 1;

  logic [PRE_W-1:0] termVal [LEVELS];
  logic [PRE_W-1:0] preCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             preLast;

  // divide ladder: each step is four times slower than the previous
  for (genvar i = 0; i < LEVELS; i++) begin : g_ladder
    assign termVal[i] = PRE_W'((64'd1 << (2 * i)) - 64'd1);
  end

  assign preLast  = (preCnt == termVal[tickSel]);
  assign gapZero  = (gapValue == '0);
  assign tickLast = stb.countEn && preLast && (gapCnt == GAP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      gapCnt <= '0;
    end else if (stb.clearAll) begin
      preCnt <= '0;
      gapCnt <= '0;
    end else if (stb.loadGap) begin
      preCnt <= '0;
      gapCnt <= gapValue;
    end else if (stb.countEn) begin
      if (preLast) begin
        preCnt <= '0;
        gapCnt <= gapCnt - GAP_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/gap_timer_ctrl.sv
module gap_timer_ctrl
  import gap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanActive,
  input  logic       blockDone,
  input  logic       gapZero,
  input  logic       tickLast,
  output gapStrobe_t stb,
  output logic       startOk
);
  logic readyQ;

  always_comb begin
    stb.clearAll = !chanActive || (blockDone && gapZero);
    stb.loadGap  = chanActive && blockDone && !gapZero;
    stb.countEn  = chanActive && !readyQ && !blockDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             readyQ <= 1'b1;
    else if (!chanActive)  readyQ <= 1'b1;
    else if (blockDone)    readyQ <= gapZero;
    else if (tickLast)     readyQ <= 1'b1;
  end

  assign startOk = chanActive && readyQ;
endmodule

// File: rtl/gap_timer.sv
module gap_timer
  import gap_timer_pkg::*;
#(
  parameter int GAP_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanActive,
  input  logic             blockDone,
  input  logic [GAP_W-1:0] gapValue,
  input  logic [SEL_W-1:0] tickSel,
  output logic             startOk
);
  gapStrobe_t stb;
  logic       gapZero;
  logic       tickLast;

  gap_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanActive(chanActive), .blockDone(blockDone),
    .gapZero(gapZero), .tickLast(tickLast), .stb(stb), .startOk(startOk)
  );

  gap_timer_dp #(.GAP_W(GAP_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .gapValue(gapValue),
    .tickSel(tickSel), .gapZero(gapZero), .tickLast(tickLast)
  );
endmodule

// File: rtl/gap_timer_chk.sv
module gap_timer_chk #(
  parameter int GAP_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanActive,
  input logic             blockDone,
  input logic [GAP_W-1:0] gapValue,
  input logic             startOk
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |-> !startOk);  // R8
  AST_ARM_ON_ACTIVATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanActive) |-> startOk);  // R2
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && blockDone && gapValue != '0) |=> !startOk);  // R3
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && blockDone && gapValue == '0) |=> (startOk || !chanActive));  // R6
  AST_RISE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startOk) |-> chanActive);  // R1
endmodule

bind gap_timer gap_timer_chk #(.GAP_W(GAP_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanActive(chanActive), .blockDone(blockDone),
  .gapValue(gapValue), .startOk(startOk)
);

// File: tb/gap_timer_bench.sv
module gap_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanActive = 1'b0;
  logic        blockDone = 1'b0;
  logic [15:0] gapValue = '0;
  logic [1:0]  tickSel = '0;
  logic        startOk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  int    waitLeft = 0;   // reference model: cycles of withheld permission
  string curReq = "R1";

  always #2.5 clk = ~clk;

  gap_timer u_gap_timer (
    .clk(clk), .rstN(rstN), .chanActive(chanActive), .blockDone(blockDone),
    .gapValue(gapValue), .tickSel(tickSel), .startOk(startOk)
  );

  function automatic int divOf(input logic [1:0] s);
    return 1 << (2 * s);
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: startOk=%0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic checkInt(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: value %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN || !chanActive)   waitLeft = 0;
    else if (blockDone)         waitLeft = gapValue * divOf(tickSel);
    else if (waitLeft > 0)      waitLeft = waitLeft - 1;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // compare with the model every cycle, away from the rising edge
  always @(negedge clk)
    if (rstN) check(startOk, chanActive && (waitLeft == 0), curReq);

  task automatic step();
    @(negedge clk); #1;
  endtask

  // pulse blockDone for one cycle, return number of low cycles until permission
  task automatic pulseAndMeasure(input logic [15:0] gap, input logic [1:0] sel,
                                 output int lows);
    gapValue = gap; tickSel = sel; blockDone = 1'b1;
    step();
    blockDone = 1'b0;
    lows = 0;
    while (!startOk && lows < 70000) begin
      lows++;
      step();
    end
  endtask

  initial begin
    int lows;
    step(); step();
    check(startOk, 1'b0, "R1");
    rstN = 1'b1;
    step();
    check(startOk, 1'b0, "R1");

    curReq = "R2";
    chanActive = 1'b1; #1;
    check(startOk, 1'b1, "R2");
    step();

    for (int s = 0; s < 4; s++) begin
      curReq = "R5";
      pulseAndMeasure(16'd3, 2'(s), lows);
      checkInt(lows, 3 * divOf(2'(s)), "R5");
      step();
    end

    curReq = "R4";
    pulseAndMeasure(16'd20, 2'd3, lows);
    checkInt(lows, 1280, "R4");
    pulseAndMeasure(16'd1, 2'd0, lows);
    checkInt(lows, 1, "R4");
    pulseAndMeasure(16'hFFFF, 2'd0, lows);
    checkInt(lows, 65535, "R4");

    curReq = "R3";
    gapValue = 16'd5; tickSel = 2'd1; blockDone = 1'b1;
    step();
    blockDone = 1'b0;
    check(startOk, 1'b0, "R3");

    curReq = "R7";
    repeat (7) step();
    pulseAndMeasure(16'd5, 2'd1, lows);
    checkInt(lows, 20, "R7");

    curReq = "R6";
    gapValue = 16'd0; blockDone = 1'b1;
    step();
    check(startOk, 1'b1, "R6");
    step();
    blockDone = 1'b0;
    check(startOk, 1'b1, "R6");

    curReq = "R8";
    gapValue = 16'd10; tickSel = 2'd2; blockDone = 1'b1;
    step();
    blockDone = 1'b0;
    repeat (4) step();
    chanActive = 1'b0; #1;
    check(startOk, 1'b0, "R8");
    step(); step();
    chanActive = 1'b1; #1;
    check(startOk, 1'b1, "R8");
    step();

    curReq = "R9";
    chanActive = 1'b0; gapValue = 16'd9; blockDone = 1'b1;
    step();
    blockDone = 1'b0;
    check(startOk, 1'b0, "R9");
    step();
    chanActive = 1'b1; #1;
    check(startOk, 1'b1, "R9");
    repeat (3) step();
    check(startOk, 1'b1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule